// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a compact processor built around one 16-bit accumulator. It runs programs held in its own 4096-word memory of 16-bit words. Every instruction word carries a 4-bit operation code in bits [15:12] and a 12-bit word address in bits [11:0]. A three-bit step counter sequences the work. The first three steps fetch and unpack the instruction, and they are the same for every instruction. The steps after them depend on the operation code. When an instruction completes, the counter returns to zero.

The fetch phase does work early when it might be useful. The program counter advances in the same step that reads the instruction word. The address field is copied into the memory address register as soon as the word is unpacked, before anyone knows whether the instruction uses it. A jump that is taken simply overwrites the advanced program counter.

Programs are placed in memory through a load port, normally while reset is held. A combinational peek port reads any memory word. The program counter and the accumulator are visible on debug outputs. A one-cycle retire pulse marks each completed instruction. A sticky halted flag reports that an undefined operation code was met.

Top module: `acc_cpu`

## Requirements
- R1: While rst_n is low, dbg_pc and dbg_ac read 0 and halted and instr_done read 0. After reset is released, execution starts by fetching the word at address 0. Reset also clears a halted state.
- R2: Each instruction word has its operation code in bits [15:12] and its address field in bits [11:0]. The word is fetched from the address in the program counter. The program counter then advances by one, modulo 4096, unless a jump or a taken branch replaces it.
- R3: Operation code 0 (load) sets the accumulator to the memory word at the address field.
- R4: Operation code 1 (store) writes the accumulator to memory at the address field and leaves the accumulator unchanged. The accumulator only ever changes in the cycle in which an instruction retires.
- R5: Operation code 2 (add) sets the accumulator to the accumulator plus the memory word at the address field, modulo 2^16.
- R6: Operation code 3 (nand) sets the accumulator to the bitwise inverse of (accumulator AND the memory word at the address field).
- R7: Operation code 4 (shift) shifts the accumulator left by one bit and puts 0 into bit 0. Its address field is ignored.
- R8: Operation code 5 (jump) loads the program counter with the address field.
- R9: Operation code 6 (branch if not zero) loads the program counter with the address field when the accumulator is nonzero. When the accumulator is zero, the program counter keeps the advanced value.
- R10: Operation codes 7 to 15 raise halted. Halted stays high until reset. While halted, the step counter stops, dbg_pc keeps the halting instruction's address plus one, dbg_ac keeps its value, and no instruction retires.
- R11: Operation codes 0 to 3 take five clock cycles. Operation codes 4 to 6 take four clock cycles. This is measured between consecutive retire pulses.
- R12: When load_we is high, load_data is written to memory at load_addr on a rising clock edge. A load write takes priority over a store in the same cycle. peek_data shows the memory word at peek_addr without any clock delay.
- R13: instr_done is high for exactly one cycle for each completed instruction. The register updates of that instruction are visible on the debug outputs after the rising edge that ends the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_we | input | 1 | Memory load write enable |
| load_addr | input | 12 | Memory load word address |
| load_data | input | 16 | Memory load write data |
| peek_addr | input | 12 | Memory peek word address |
| peek_data | output | 16 | Memory word at peek_addr |
| halted | output | 1 | Sticky flag raised by an undefined operation code |
| instr_done | output | 1 | One-cycle pulse when an instruction retires |
| dbg_pc | output | 12 | Program counter |
| dbg_ac | output | 16 | Accumulator |

## Verification
A wrong step count or a missed program-counter advance shows up on dbg_pc within one instruction. It also shifts the spacing of instr_done pulses, and that spacing is compared against the four or five cycles expected from the operation code. A wrong ALU result or a wrong operand fetch shows up on dbg_ac in the cycle after the pulse of the same instruction. A store with a wrong address or wrong data stays hidden until the memory is read through the peek port, so each program ends with a memory readback. A faulty halt shows up as a program counter or accumulator that keeps moving after halted rises, or as a retire pulse while halted.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W  = 4;
  localparam int STEP_W = 3;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd0;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd2;
  localparam logic [OPC_W-1:0] OP_NAND  = 4'd3;
  localparam logic [OPC_W-1:0] OP_SHIFT = 4'd4;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'd5;
  localparam logic [OPC_W-1:0] OP_BRNZ  = 4'd6;

  localparam logic [STEP_W-1:0] ST_ADDR   = 3'd0;
  localparam logic [STEP_W-1:0] ST_READ   = 3'd1;
  localparam logic [STEP_W-1:0] ST_UNPACK = 3'd2;
  localparam logic [STEP_W-1:0] ST_EXEC_A = 3'd3;
  localparam logic [STEP_W-1:0] ST_EXEC_B = 3'd4;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_NAND,
    ALU_SHL
  } alu_op_e;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_mdr;
    logic    mdr_from_mem;
    logic    mdr_from_ac;
    logic    pc_inc;
    logic    pc_from_mar;
    logic    ir_load;
    logic    ac_we;
    alu_op_e alu_op;
    logic    mem_we;
    logic    done;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ext_we,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_wdata,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  // the external load port wins over a store in the same cycle
  always_comb begin
    wr_en   = ext_we | cpu_we;
    wr_addr = ext_we ? ext_addr  : cpu_addr;
    wr_data = ext_we ? ext_wdata : cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      words[wr_addr] <= wr_data;
    end
  end

  assign cpu_rdata = words[cpu_addr];
  assign dbg_rdata = words[dbg_addr];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (op)
      ALU_ADD:  res = acc + opnd;
      ALU_NAND: res = ~(acc & opnd);
      ALU_SHL:  res = {acc[DATA_W-2:0], 1'b0};
      default:  res = opnd;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opc,
  input  logic              acc_nz,
  output ctrl_t             ctl,
  output logic [STEP_W-1:0] step,
  output logic              halted
);
  logic [STEP_W-1:0] step_q, step_nxt;
  logic              halt_q, halt_nxt;

  always_comb begin
    ctl      = '0;
    ctl.alu_op = ALU_PASS;
    step_nxt = step_q + STEP_W'(1);
    halt_nxt = halt_q;
    if (halt_q) begin
      step_nxt = step_q;
    end else begin
      unique case (step_q)
        ST_ADDR:   ctl.mar_from_pc = 1'b1;
        ST_READ: begin
          ctl.mdr_from_mem = 1'b1;
          ctl.pc_inc       = 1'b1;
        end
        ST_UNPACK: begin
          ctl.ir_load      = 1'b1;
          ctl.mar_from_mdr = 1'b1;
        end
        ST_EXEC_A: begin
          unique case (opc)
            OP_LOAD, OP_ADD, OP_NAND: ctl.mdr_from_mem = 1'b1;
            OP_STORE:                 ctl.mdr_from_ac  = 1'b1;
            OP_SHIFT: begin
              ctl.ac_we  = 1'b1;
              ctl.alu_op = ALU_SHL;
              ctl.done   = 1'b1;
              step_nxt   = ST_ADDR;
            end
            OP_JUMP: begin
              ctl.pc_from_mar = 1'b1;
              ctl.done        = 1'b1;
              step_nxt        = ST_ADDR;
            end
            OP_BRNZ: begin
              ctl.pc_from_mar = acc_nz;
              ctl.done        = 1'b1;
              step_nxt        = ST_ADDR;
            end
            default: begin
              halt_nxt = 1'b1;
              step_nxt = step_q;
            end
          endcase
        end
        ST_EXEC_B: begin
          ctl.done = 1'b1;
          step_nxt = ST_ADDR;
          unique case (opc)
            OP_LOAD:  ctl.ac_we = 1'b1;
            OP_STORE: ctl.mem_we = 1'b1;
            OP_ADD: begin
              ctl.ac_we  = 1'b1;
              ctl.alu_op = ALU_ADD;
            end
            OP_NAND: begin
              ctl.ac_we  = 1'b1;
              ctl.alu_op = ALU_NAND;
            end
            default: ctl.done = 1'b0;
          endcase
        end
        default: step_nxt = ST_ADDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_ADDR;
      halt_q <= 1'b0;
    end else begin
      step_q <= step_nxt;
      halt_q <= halt_nxt;
    end
  end

  assign step   = step_q;
  assign halted = halt_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_we,
  input  logic [ADDR_W-1:0]         load_addr,
  input  logic [OPC_W+ADDR_W-1:0]   load_data,
  input  logic [ADDR_W-1:0]         peek_addr,
  output logic [OPC_W+ADDR_W-1:0]   peek_data,
  output logic                      halted,
  output logic                      instr_done,
  output logic [ADDR_W-1:0]         dbg_pc,
  output logic [OPC_W+ADDR_W-1:0]   dbg_ac
);
  localparam int DATA_W = OPC_W + ADDR_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  logic [ADDR_W-1:0] pc, pc_nxt, mar, mar_nxt;
  logic [DATA_W-1:0] mdr, mdr_nxt, ac, ac_nxt;
  logic [OPC_W-1:0]  ir, ir_nxt;
  logic              pc_en, mar_en, mdr_en, ir_en, ac_en;
  logic [DATA_W-1:0] mem_rdata, alu_res;
  logic [STEP_W-1:0] step;
  ctrl_t             ctl;

  acc_cpu_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .opc    (ir),
    .acc_nz (|ac),
    .ctl    (ctl),
    .step   (step),
    .halted (halted)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) alu_i (
    .op   (ctl.alu_op),
    .acc  (ac),
    .opnd (mdr),
    .res  (alu_res)
  );

  acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk       (clk),
    .cpu_we    (ctl.mem_we),
    .cpu_addr  (mar),
    .cpu_wdata (mdr),
    .cpu_rdata (mem_rdata),
    .ext_we    (load_we),
    .ext_addr  (load_addr),
    .ext_wdata (load_data),
    .dbg_addr  (peek_addr),
    .dbg_rdata (peek_data)
  );

  // next-state of the datapath registers
  always_comb begin
    pc_en   = ctl.pc_inc | ctl.pc_from_mar;
    pc_nxt  = ctl.pc_from_mar ? mar : pc + ADDR_W'(1);
    mar_en  = ctl.mar_from_pc | ctl.mar_from_mdr;
    mar_nxt = ctl.mar_from_pc ? pc : mdr[ADDR_W-1:0];
    mdr_en  = ctl.mdr_from_mem | ctl.mdr_from_ac;
    mdr_nxt = ctl.mdr_from_ac ? ac : mem_rdata;
    ir_en   = ctl.ir_load;
    ir_nxt  = mdr[DATA_W-1 -: OPC_W];
    ac_en   = ctl.ac_we;
    ac_nxt  = alu_res;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      if (pc_en)  pc  <= pc_nxt;
      if (mar_en) mar <= mar_nxt;
      if (mdr_en) mdr <= mdr_nxt;
      if (ir_en)  ir  <= ir_nxt;
      if (ac_en)  ac  <= ac_nxt;
    end
  end

  assign instr_done = ctl.done;
  assign dbg_pc     = pc;
  assign dbg_ac     = ac;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STEP_W-1:0] step,
  input logic              halted,
  input logic              instr_done,
  input logic [ADDR_W-1:0] dbg_pc,
  input logic [DATA_W-1:0] dbg_ac
);
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(dbg_pc) && $stable(dbg_ac)));

  assert_no_retire_halted_R13: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !instr_done);

  assert_retire_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_READ && !halted) |=> (dbg_pc == ADDR_W'($past(dbg_pc) + 1'b1)));

  assert_pc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_ADDR || step == ST_UNPACK || step == ST_EXEC_B) |=> $stable(dbg_pc));

  assert_ac_at_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(dbg_ac));

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .step       (step),
  .halted     (halted),
  .instr_done (instr_done),
  .dbg_pc     (dbg_pc),
  .dbg_ac     (dbg_ac)
);

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_we;
  logic [AW-1:0] load_addr;
  logic [DW-1:0] load_data;
  logic [AW-1:0] peek_addr;
  logic [DW-1:0] peek_data;
  logic          halted, instr_done;
  logic [AW-1:0] dbg_pc;
  logic [DW-1:0] dbg_ac;

  int checks   = 0;
  int failures = 0;

  logic [DW-1:0] ref_mem [4096];
  logic [AW-1:0] ref_pc;
  logic [DW-1:0] ref_ac;

  always #5 clk = ~clk;

  acc_cpu #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .halted(halted), .instr_done(instr_done), .dbg_pc(dbg_pc), .dbg_ac(dbg_ac)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    load_we = 1'b1; load_addr = a; load_data = d;
    ref_mem[a] = d;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_pc = '0; ref_ac = '0;
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3 load";
      4'd1: return "R4 store";
      4'd2: return "R5 add";
      4'd3: return "R6 nand";
      4'd4: return "R7 shift";
      4'd5: return "R8 jump";
      default: return "R9 branch";
    endcase
  endfunction

  // release reset and run until the model meets an undefined opcode
  task automatic run_prog(input string name);
    int  since = 0;
    bit  first = 1'b1;
    bit  ok;
    logic [3:0]    op;
    logic [AW-1:0] fa;
    logic [DW-1:0] w;
    int  lat;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 300; k++) begin
      w  = ref_mem[ref_pc];
      op = w[15:12];
      fa = w[11:0];
      if (op > 4'd6) begin
        repeat (8) @(negedge clk);
        check({"R10 halted ", name}, 32'(halted), 32'd1);
        check({"R10 pc after halt ", name}, 32'(dbg_pc), 32'(AW'(ref_pc + 1'b1)));
        check({"R10 ac after halt ", name}, 32'(dbg_ac), 32'(ref_ac));
        return;
      end
      ok = 1'b0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        since++;
        if (instr_done) begin ok = 1'b1; break; end
      end
      if (!ok) begin
        check({"R13 retire seen ", name}, 32'd0, 32'd1);
        return;
      end
      lat = (op <= 4'd3) ? 5 : 4;
      if (!first) check({"R11 latency ", req_of(op)}, 32'(since), 32'(lat));
      first = 1'b0;
      // reference model of one instruction
      ref_pc = AW'(ref_pc + 1'b1);
      case (op)
        4'd0: ref_ac = ref_mem[fa];
        4'd1: ref_mem[fa] = ref_ac;
        4'd2: ref_ac = ref_ac + ref_mem[fa];
        4'd3: ref_ac = ~(ref_ac & ref_mem[fa]);
        4'd4: ref_ac = {ref_ac[DW-2:0], 1'b0};
        4'd5: ref_pc = fa;
        default: if (ref_ac != '0) ref_pc = fa;
      endcase
      @(negedge clk);
      since = 1;
      check({req_of(op), " ac"}, 32'(dbg_ac), 32'(ref_ac));
      check({"R2 pc after ", req_of(op)}, 32'(dbg_pc), 32'(ref_pc));
      check("R13 pulse one cycle", 32'(instr_done), 32'd0);
    end
  endtask

  task automatic peek_check(input string tag, input logic [AW-1:0] a);
    peek_addr = a;
    #1;
    check(tag, 32'(peek_data), 32'(ref_mem[a]));
  endtask

  task automatic t_reset();
    hold_reset();
    #1;
    check("R1 pc in reset", 32'(dbg_pc), 32'd0);
    check("R1 ac in reset", 32'(dbg_ac), 32'd0);
    check("R1 halted in reset", 32'(halted), 32'd0);
    check("R1 done in reset", 32'(instr_done), 32'd0);
  endtask

  task automatic t_load_port();
    hold_reset();
    preload(12'hFFF, 16'hA5C3);
    preload(12'h000, 16'h0F0F);
    preload(12'h7FF, 16'hFFFF);
    peek_check("R12 top word", 12'hFFF);
    peek_check("R12 word 0", 12'h000);
    peek_check("R12 mid word", 12'h7FF);
  endtask

  task automatic t_arith();
    hold_reset();
    preload(12'h000, 16'h0100);
    preload(12'h001, 16'h2101);
    preload(12'h002, 16'h1200);
    preload(12'h003, 16'h3102);
    preload(12'h004, 16'h4ABC);
    preload(12'h005, 16'h1201);
    preload(12'h006, 16'h0200);
    preload(12'h007, 16'hF000);
    preload(12'h100, 16'h1234);
    preload(12'h101, 16'hF000);
    preload(12'h102, 16'h00FF);
    run_prog("arith");
    check("R5 add wraps then R6 R7 chain", 32'(dbg_ac), 32'h0234);
    peek_check("R4 store of sum", 12'h200);
    peek_check("R4 store of shifted", 12'h201);
    check("R7 expected shifted word", 32'(ref_mem[12'h201]), 32'hFF96);
  endtask

  task automatic t_branch();
    hold_reset();
    preload(12'h000, 16'h0100);
    preload(12'h001, 16'h4000);
    preload(12'h002, 16'h6001);
    preload(12'h003, 16'h5005);
    preload(12'h004, 16'h0101);
    preload(12'h005, 16'h7000);
    preload(12'h100, 16'h4000);
    preload(12'h101, 16'h5555);
    run_prog("branch");
    check("R9 final pc beyond halt", 32'(dbg_pc), 32'h006);
    check("R8 skipped load kept ac zero", 32'(dbg_ac), 32'h0000);
  endtask

  task automatic t_halt();
    bit seen;
    hold_reset();
    preload(12'h000, 16'h0103);
    preload(12'h001, 16'h8123);
    preload(12'h103, 16'hBEEF);
    run_prog("halt");
    seen = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (instr_done) seen = 1'b1;
    end
    check("R10 no retire while halted", 32'(seen), 32'd0);
    check("R10 pc frozen", 32'(dbg_pc), 32'h002);
    check("R10 ac frozen", 32'(dbg_ac), 32'hBEEF);
    hold_reset();
    #1;
    check("R1 reset clears halt", 32'(halted), 32'd0);
    check("R1 reset clears ac", 32'(dbg_ac), 32'd0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_we = 1'b0; load_addr = '0; load_data = '0; peek_addr = '0;
    ref_pc = '0; ref_ac = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_load_port();
    t_arith();
    t_branch();
    t_halt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule